// File: doc/BRIEF.md
# Single-Line Interrupt Trigger Controller

This block watches one asynchronous interrupt pin, typically a non-maskable interrupt request from off-chip, and presents a single interrupt request to a parent interrupt controller. The pin is brought into the clock domain through a flop synchroniser. Software programs a trigger code that selects level or edge sensing and its polarity. When the programmed condition is seen, a sticky pending flag is set. That flag is gated by an enable bit and registered onto the output.

Software talks to the block through a plain register port with one-cycle writes and combinational reads. It clears the pending flag by writing a one to it. In edge modes that write acknowledges the event before it is serviced. In level modes the same write ends the interrupt after servicing, and the flag sets again at once if the pin is still active. A parameter picks one of two placements for the enable and pending registers, so the block can sit under either address map.

Bring-up takes two writes: mask the line through the enable register, then write a one to the pending bit to drop any stale event.

Top module: `nmi_line_ctrl`

## Requirements
- R1: After reset the trigger register, the enable bit, the pending bit and `irqOut` are all zero. A read of any address other than 0x0, 0x4 or 0x8 returns zero.
- R2: Trigger code 0 in trigger register bits [1:0] is active-low level: the pending bit sets while the synchronised pin is 0.
- R3: Trigger code 1 is falling edge: the pending bit sets once per 1-to-0 transition of the synchronised pin. Holding the pin low after a clear does not set it again.
- R4: Trigger code 2 is active-high level: the pending bit sets while the synchronised pin is 1.
- R5: Trigger code 3 is rising edge: the pending bit sets once per 0-to-1 transition of the synchronised pin.
- R6: The pending bit is bit 0 of the pending register. Writing 1 to it clears it, and writing 0 leaves it unchanged.
- R7: `irqOut` is the pending bit ANDed with enable register bit 0, taken through one register. While the enable bit is 0, `irqOut` stays 0 and the pending bit can still be read.
- R8: Trigger register bits above [1:0] are plain read/write storage that reads back as written. Only bits [1:0] affect the trigger.
- R9: In the two level modes, a clear written while the pin is active reads 0 on the cycle after the write. The pending bit reads 1 again one cycle later.
- R10: With `LAYOUT`=0 the trigger register is at 0x0, pending at 0x4 and enable at 0x8. With `LAYOUT`=1 the trigger register is at 0x0, enable at 0x4 and pending at 0x8.
- R11: A pin change reaches the pending bit on the third rising clock edge after it and reaches `irqOut` on the fourth.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| regAddr | input | ADDR_W | Register byte address |
| regWe | input | 1 | Write strobe, one cycle per write |
| regWdata | input | DATA_W | Write data |
| regRdata | output | DATA_W | Read data for `regAddr`, combinational |
| lineIn | input | 1 | Asynchronous interrupt pin |
| irqOut | output | 1 | Registered interrupt request to the parent controller |

## Verification
A table drives every trigger code through each pair of start and end pin levels. A design that swapped polarities or mixed up level and edge sensing would leave the wrong pending value and the wrong output. Directed tests cover three cases:
- Writing zero to the pending bit, which a design that decoded the whole data word as a clear would get wrong.
- A clear while a level is still active, where a design that let the set win would never show the cleared cycle, and one that dropped the set would stay cleared.
- Junk in the upper trigger bits, and the second address layout, where a swapped decode would write the enable when a clear was meant.

// File: rtl/nmi_line_pkg.sv
package nmi_line_pkg;

  typedef enum logic [1:0] {
    TRIG_LVL_LOW   = 2'd0,
    TRIG_EDGE_FALL = 2'd1,
    TRIG_LVL_HIGH  = 2'd2,
    TRIG_EDGE_RISE = 2'd3
  } trigMode_e;

  typedef enum logic [1:0] {
    SEL_NONE = 2'd0,
    SEL_CTRL = 2'd1,
    SEL_EN   = 2'd2,
    SEL_PEND = 2'd3
  } rdSel_e;

  typedef struct packed {
    logic   wrCtrl;
    logic   wrEn;
    logic   clrPend;
    rdSel_e rdSel;
  } regStb_t;

endpackage

// File: rtl/nmi_line_decode.sv
module nmi_line_decode
  import nmi_line_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int LAYOUT = 0
) (
  input  logic [ADDR_W-1:0] regAddr,
  input  logic              regWe,
  input  logic              wdBit0,
  output regStb_t           stb
);

  localparam logic [ADDR_W-1:0] CTRL_A = ADDR_W'(0);
  logic [ADDR_W-1:0] enA;
  logic [ADDR_W-1:0] pendA;

  generate
    if (LAYOUT == 0) begin : g_layoutA
      assign pendA = ADDR_W'(4);
      assign enA   = ADDR_W'(8);
    end else begin : g_layoutB
      assign enA   = ADDR_W'(4);
      assign pendA = ADDR_W'(8);
    end
  endgenerate

  logic hitCtrl, hitEn, hitPend;

  always_comb begin
    hitCtrl = (regAddr == CTRL_A);
    hitEn   = (regAddr == enA);
    hitPend = (regAddr == pendA);

    stb.wrCtrl  = regWe && hitCtrl;
    stb.wrEn    = regWe && hitEn;
    stb.clrPend = regWe && hitPend && wdBit0;

    if (hitCtrl)      stb.rdSel = SEL_CTRL;
    else if (hitEn)   stb.rdSel = SEL_EN;
    else if (hitPend) stb.rdSel = SEL_PEND;
    else              stb.rdSel = SEL_NONE;
  end

endmodule

// File: rtl/nmi_line_datapath.sv
module nmi_line_datapath
  import nmi_line_pkg::*;
#(
  parameter int DATA_W      = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              lineIn,
  input  regStb_t           stb,
  input  logic [DATA_W-1:0] regWdata,
  output logic [DATA_W-1:0] regRdata,
  output logic              pendBit,
  output logic              enBit,
  output logic              irqOut
);

  logic [SYNC_STAGES-1:0] syncQ;
  logic                   lineOld;
  logic                   lineNow;
  logic [DATA_W-1:0]      ctrlQ;
  logic                   pendQ;
  logic                   enQ;
  logic                   irqQ;
  logic                   hit;
  trigMode_e              mode;

  // Synchroniser resets to the inactive level of the reset-default mode.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      syncQ   <= '1;
      lineOld <= 1'b1;
    end else begin
      syncQ   <= {syncQ[SYNC_STAGES-2:0], lineIn};
      lineOld <= lineNow;
    end
  end

  assign lineNow = syncQ[SYNC_STAGES-1];
  assign mode    = trigMode_e'(ctrlQ[1:0]);

  always_comb begin
    unique case (mode)
      TRIG_LVL_LOW:   hit = !lineNow;
      TRIG_EDGE_FALL: hit = lineOld && !lineNow;
      TRIG_LVL_HIGH:  hit = lineNow;
      TRIG_EDGE_RISE: hit = !lineOld && lineNow;
      default:        hit = 1'b0;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ctrlQ <= '0;
      enQ   <= 1'b0;
      pendQ <= 1'b0;
      irqQ  <= 1'b0;
    end else begin
      if (stb.wrCtrl) ctrlQ <= regWdata;
      if (stb.wrEn)   enQ   <= regWdata[0];
      // A clear wins over a set arriving in the same cycle.
      if (stb.clrPend)  pendQ <= 1'b0;
      else if (hit)     pendQ <= 1'b1;
      irqQ <= pendQ && enQ;
    end
  end

  always_comb begin
    regRdata = '0;
    unique case (stb.rdSel)
      SEL_CTRL: regRdata = ctrlQ;
      SEL_EN:   regRdata[0] = enQ;
      SEL_PEND: regRdata[0] = pendQ;
      default:  regRdata = '0;
    endcase
  end

  assign pendBit = pendQ;
  assign enBit   = enQ;
  assign irqOut  = irqQ;

endmodule

// File: rtl/nmi_line_ctrl.sv
module nmi_line_ctrl
  import nmi_line_pkg::*;
#(
  parameter int ADDR_W      = 4,
  parameter int DATA_W      = 32,
  parameter int SYNC_STAGES = 2,
  parameter int LAYOUT      = 0
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic              regWe,
  input  logic [DATA_W-1:0] regWdata,
  output logic [DATA_W-1:0] regRdata,
  input  logic              lineIn,
  output logic              irqOut
);

  regStb_t stb;
  logic    pendBit;
  logic    enBit;

  nmi_line_decode #(
    .ADDR_W(ADDR_W),
    .LAYOUT(LAYOUT)
  ) u_decode (
    .regAddr(regAddr),
    .regWe  (regWe),
    .wdBit0 (regWdata[0]),
    .stb    (stb)
  );

  nmi_line_datapath #(
    .DATA_W     (DATA_W),
    .SYNC_STAGES(SYNC_STAGES)
  ) u_datapath (
    .clk     (clk),
    .rstN    (rstN),
    .lineIn  (lineIn),
    .stb     (stb),
    .regWdata(regWdata),
    .regRdata(regRdata),
    .pendBit (pendBit),
    .enBit   (enBit),
    .irqOut  (irqOut)
  );

endmodule

// File: rtl/nmi_line_ctrl_chk.sv
module nmi_line_ctrl_chk #(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 32,
  parameter int LAYOUT = 0
) (
  input logic              clk,
  input logic              rstN,
  input logic [ADDR_W-1:0] regAddr,
  input logic              regWe,
  input logic [DATA_W-1:0] regWdata,
  input logic [DATA_W-1:0] regRdata,
  input logic              irqOut,
  input logic              pendBit,
  input logic              enBit
);

  localparam logic [ADDR_W-1:0] PEND_A = (LAYOUT == 0) ? ADDR_W'(4) : ADDR_W'(8);
  localparam logic [ADDR_W-1:0] EN_A   = (LAYOUT == 0) ? ADDR_W'(8) : ADDR_W'(4);

  logic mapped;
  assign mapped = (regAddr == ADDR_W'(0)) || (regAddr == ADDR_W'(4)) || (regAddr == ADDR_W'(8));

  AST_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    !mapped |-> regRdata == '0);  // R1

  AST_PEND_W1C: assert property (@(posedge clk) disable iff (!rstN)
    regWe && regAddr == PEND_A && regWdata[0] |=> !pendBit);  // R6

  AST_PEND_W0_KEEP: assert property (@(posedge clk) disable iff (!rstN)
    regWe && regAddr == PEND_A && !regWdata[0] && pendBit |=> pendBit);  // R6

  AST_MASK_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    !enBit |=> !irqOut);  // R7

  AST_IRQ_NEEDS_PEND: assert property (@(posedge clk) disable iff (!rstN)
    irqOut |-> $past(pendBit));  // R7

  AST_EN_WRITE: assert property (@(posedge clk) disable iff (!rstN)
    regWe && regAddr == EN_A |=> enBit == $past(regWdata[0]));  // R10

endmodule

bind nmi_line_ctrl nmi_line_ctrl_chk #(
  .ADDR_W(ADDR_W),
  .DATA_W(DATA_W),
  .LAYOUT(LAYOUT)
) u_chk (.*);

// File: tb/test_nmi_line_ctrl.sv
module test_nmi_line_ctrl;

  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W     = 4;
  localparam int DATA_W     = 32;
  localparam logic [ADDR_W-1:0] A_CTRL = 4'h0;
  localparam logic [ADDR_W-1:0] A_PEND = 4'h4;
  localparam logic [ADDR_W-1:0] A_EN   = 4'h8;

  // {mode[1:0], startLevel, endLevel, expectedPending}
  localparam logic [4:0] VEC [16] = '{
    5'b00_00_1, 5'b00_01_1, 5'b00_10_1, 5'b00_11_0,
    5'b01_00_0, 5'b01_01_0, 5'b01_10_1, 5'b01_11_0,
    5'b10_00_0, 5'b10_01_1, 5'b10_10_1, 5'b10_11_1,
    5'b11_00_0, 5'b11_01_1, 5'b11_10_0, 5'b11_11_0
  };

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic [ADDR_W-1:0] regAddr = '0;
  logic              regWe = 1'b0;
  logic [DATA_W-1:0] regWdata = '0;
  logic [DATA_W-1:0] regRdata;
  logic              lineIn = 1'b1;
  logic              irqOut;
  logic [ADDR_W-1:0] aAddr = '0;
  logic              aWe = 1'b0;
  logic [DATA_W-1:0] aWdata = '0;
  logic [DATA_W-1:0] aRdata;
  logic              aIrq;

  int checks = 0;
  int errors = 0;
  logic [DATA_W-1:0] rv;

  always #(CLK_PERIOD/2) clk = ~clk;

  nmi_line_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .LAYOUT(0)) i_nmi_line_ctrl (
    .clk(clk), .rstN(rstN), .regAddr(regAddr), .regWe(regWe), .regWdata(regWdata),
    .regRdata(regRdata), .lineIn(lineIn), .irqOut(irqOut));

  nmi_line_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .LAYOUT(1)) i_nmi_line_ctrl_alt (
    .clk(clk), .rstN(rstN), .regAddr(aAddr), .regWe(aWe), .regWdata(aWdata),
    .regRdata(aRdata), .lineIn(lineIn), .irqOut(aIrq));

  task automatic chk(input string req, input logic [DATA_W-1:0] act, input logic [DATA_W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [ADDR_W-1:0] a, input logic [DATA_W-1:0] d);
    @(negedge clk); regAddr = a; regWdata = d; regWe = 1'b1;
    @(negedge clk); regWe = 1'b0;
  endtask

  task automatic rd(input logic [ADDR_W-1:0] a, output logic [DATA_W-1:0] d);
    @(negedge clk); regAddr = a; #1; d = regRdata;
  endtask

  task automatic wrAlt(input logic [ADDR_W-1:0] a, input logic [DATA_W-1:0] d);
    @(negedge clk); aAddr = a; aWdata = d; aWe = 1'b1;
    @(negedge clk); aWe = 1'b0;
  endtask

  task automatic rdAlt(input logic [ADDR_W-1:0] a, output logic [DATA_W-1:0] d);
    @(negedge clk); aAddr = a; #1; d = aRdata;
  endtask

  task automatic waitCycles(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic finishRun();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finishRun();
  end

  initial begin
    waitCycles(3);
    rstN = 1'b1;
    waitCycles(2);

    // R1: reset state and unmapped reads
    rd(A_CTRL, rv); chk("R1 ctrl", rv, '0);
    rd(A_EN, rv);   chk("R1 enable", rv, '0);
    rd(A_PEND, rv); chk("R1 pending", rv, '0);
    rd(4'hC, rv);   chk("R1 unmapped", rv, '0);
    chk("R1 irqOut", {31'd0, irqOut}, 32'd1 & 32'd0);

    // Bring-up: mask, then drop stale events; then unmask for the table
    wr(A_EN, 32'd0);
    wr(A_PEND, 32'd1);
    wr(A_EN, 32'd1);

    for (int i = 0; i < 16; i++) begin
      logic [1:0] m;
      string tag;
      m = VEC[i][4:3];
      tag = (m == 2'd0) ? "R2" : (m == 2'd1) ? "R3" : (m == 2'd2) ? "R4" : "R5";
      wr(A_CTRL, {30'd0, m});
      lineIn = VEC[i][2];
      waitCycles(5);
      wr(A_PEND, 32'd1);
      lineIn = VEC[i][1];
      waitCycles(5);
      rd(A_PEND, rv);
      chk(tag, rv, {31'd0, VEC[i][0]});
      chk(tag, {31'd0, irqOut}, {31'd0, VEC[i][0]});
    end

    // R11: latency from pin change to pending and to irqOut (rising edge mode)
    wr(A_CTRL, 32'd3);
    lineIn = 1'b0;
    waitCycles(5);
    wr(A_PEND, 32'd1);
    regAddr = A_PEND;
    lineIn = 1'b1;               // changed at a negedge
    @(negedge clk); #1; chk("R11 pend after 1 edge", regRdata, 32'd0);
    @(negedge clk); #1; chk("R11 pend after 2 edges", regRdata, 32'd0);
    @(negedge clk); #1; chk("R11 pend after 3 edges", regRdata, 32'd1);
    chk("R11 irq after 3 edges", {31'd0, irqOut}, 32'd0);
    @(negedge clk); #1; chk("R11 irq after 4 edges", {31'd0, irqOut}, 32'd1);

    // R6: writing zero keeps pending, writing one clears it
    wr(A_PEND, 32'hFFFF_FFFE);
    rd(A_PEND, rv); chk("R6 write zero keeps", rv, 32'd1);
    wr(A_PEND, 32'd1);
    rd(A_PEND, rv); chk("R6 write one clears", rv, 32'd0);

    // R3: falling edge, held low after clear, no re-set
    wr(A_CTRL, 32'd1);
    lineIn = 1'b0;
    waitCycles(5);
    rd(A_PEND, rv); chk("R3 falling sets", rv, 32'd1);
    wr(A_PEND, 32'd1);
    waitCycles(5);
    rd(A_PEND, rv); chk("R3 held low no re-set", rv, 32'd0);

    // R9: level clear while active reads 0 once, then 1
    wr(A_CTRL, 32'd0);
    waitCycles(4);
    wr(A_PEND, 32'd1);
    regAddr = A_PEND;
    #1; chk("R9 cleared cycle", regRdata, 32'd0);
    @(negedge clk); #1; chk("R9 re-set next cycle", regRdata, 32'd1);

    // R7: masked line keeps irqOut low while pending stays readable
    wr(A_EN, 32'd0);
    waitCycles(2);
    chk("R7 masked irq", {31'd0, irqOut}, 32'd0);
    rd(A_PEND, rv); chk("R7 pending visible", rv, 32'd1);
    wr(A_EN, 32'd1);
    @(negedge clk); #1; chk("R7 unmasked irq", {31'd0, irqOut}, 32'd1);

    // R8: upper trigger bits are storage; bits [1:0] alone choose rising edge
    lineIn = 1'b0;
    wr(A_CTRL, 32'hDEAD_BEE3);
    rd(A_CTRL, rv); chk("R8 readback", rv, 32'hDEAD_BEE3);
    waitCycles(4);
    wr(A_PEND, 32'd1);
    waitCycles(4);
    rd(A_PEND, rv); chk("R8 low held no set", rv, 32'd0);
    lineIn = 1'b1;
    waitCycles(5);
    rd(A_PEND, rv); chk("R8 rising sets", rv, 32'd1);
    rd(A_CTRL, rv); chk("R8 upper kept", rv, 32'hDEAD_BEE3);

    // R10: second layout swaps enable and pending
    wrAlt(4'h8, 32'd1);
    wrAlt(4'h4, 32'd1);
    rdAlt(4'h4, rv); chk("R10 alt enable at 0x4", rv, 32'd1);
    rdAlt(4'h8, rv); chk("R10 alt pending clear", rv, 32'd0);
    lineIn = 1'b0;
    waitCycles(5);
    rdAlt(4'h8, rv); chk("R10 alt pending at 0x8", rv, 32'd1);
    chk("R10 alt irq", {31'd0, aIrq}, 32'd1);
    rd(A_EN, rv); chk("R10 main enable at 0x8", rv, 32'd1);

    finishRun();
  end

endmodule